// File: doc/BRIEF.md
# UART FIFO and Interrupt Section

This block is the byte-buffering and interrupt part of a 16550-style UART, seen from a small register bus. It holds one transmit FIFO and one receive FIFO. It keeps a flag that shows whether the transmit side is completely empty, and it drives one interrupt line. That line carries two sources: a receive-fill event and a transmit-drained event. A shift-register transmitter pulls bytes through a valid/ready handshake. A receiver pushes bytes through a valid strobe. Bit timing, baud generation, modem lines and line-error detection belong to other blocks.

Software writes bytes to the data register and reads received bytes from the same address. The transmit-empty flag drops on the first write and comes back only when every queued byte has left. No flag or interrupt reports a partly drained transmit FIFO. The drained interrupt appears only after at least one byte has been written and then sent, so software starts a transfer with a first write. The receive interrupt threshold comes from a fixed table of four uneven levels. With the FIFOs disabled, each direction holds a single byte.

Register map, 3-bit address: 0 = data (a write queues a transmit byte, a read pops a receive byte and returns 0 when the receive FIFO is empty); 1 = interrupt enable (bit 0 enables the receive source, bit 1 enables the drained source; reads back in bits 1:0); 2 = a read gives the interrupt identity, a write sets FIFO control; 3 = a read gives line status.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset the line status reads 0x20, the interrupt identity reads 0x01, the interrupt enable reads 0x00, `irq` is 0 and `tx_valid` is 0.
- R2: Capacity is 16 bytes when FIFO control bit 0 is set and 1 byte when it is clear. A data write to a full transmit FIFO is dropped and sets status bit 6. Fullness is judged before any same-cycle pop. Status bit 6 stays set until the status register is read.
- R3: A receive byte that arrives while the receive FIFO is full is dropped, even if a read pops a byte in the same cycle. It sets status bit 1, which stays set until the status register is read.
- R4: Transmit bytes appear on `tx_data` in write order while `tx_valid` is 1. A byte leaves on each cycle where `tx_valid` and `tx_ready` are both 1.
- R5: Status bit 5 is 1 exactly when the transmit FIFO is empty. It reads 0 from the cycle after an accepted data write until the last byte has left.
- R6: The drained event becomes pending when the last transmit byte leaves in a cycle with no accepted data write. It reaches `irq` and identity code 0x02 only while enable bit 1 is set. Setting the enable alone, with nothing sent, raises nothing.
- R7: A pending drained event is cleared by a data write, or by a read of the identity register that returns 0x02.
- R8: FIFO control bits 7:6 select the receive threshold: 00 → 1, 01 → 4, 10 → 8, 11 → 14 bytes. With the FIFOs disabled the threshold is 1. While enable bit 0 is set and the receive count is at or above the threshold, `irq` is 1 and the identity reads 0x04.
- R9: When both sources are active, the identity reports the receive source (0x04), and reading it leaves the drained event pending.
- R10: FIFO control bit 1 empties the receive FIFO and bit 2 empties the transmit FIFO, each in one clock. The enable and threshold fields written in the same control write take effect, and the other FIFO is untouched. A change of bit 0 empties both FIFOs.
- R11: A data read returns the oldest received byte, and status bit 0 is 1 while any received byte is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read has side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the same cycle as `reg_rd` |
| tx_valid | output | 1 | Transmit FIFO holds a byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_valid | input | 1 | Receiver delivers a byte |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the transmitter taking the last queued byte while software writes a new one. The bench holds the transmit FIFO at one byte and raises the data write and `tx_ready` on the same falling edge. It then expects the new byte on `tx_data`, status bit 5 clear and no interrupt. The second pair is a receive byte arriving at a full FIFO in the same cycle as a data read. Here the bench expects the read to return the oldest byte, the overrun flag to be set and the new byte never to appear, which it confirms by reading out the remaining fifteen bytes.

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
  parameter int DEPTH = 16  // power of two
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] LV0 = CW'(1);
  localparam logic [CW-1:0] LV1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LV2 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LV3 = CW'(DEPTH - 2);

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, cap, level;
  logic          fifo_en, thre_pend, tx_ovf, rx_ovr;
  logic [1:0]    trig, ier;
  logic [7:0]    iir, lsr;
  logic          unused_bits;

  wire wr_data = reg_wr && reg_addr == 3'd0;
  wire wr_ier  = reg_wr && reg_addr == 3'd1;
  wire wr_fcr  = reg_wr && reg_addr == 3'd2;
  wire rd_data = reg_rd && reg_addr == 3'd0;
  wire rd_iir  = reg_rd && reg_addr == 3'd2;
  wire rd_lsr  = reg_rd && reg_addr == 3'd3;

  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);
  wire tx_full = tx_cnt >= cap;
  wire rx_full = rx_cnt >= cap;
  wire thre    = tx_cnt == '0;
  wire rx_any  = rx_cnt != '0;

  assign tx_valid = !thre;
  assign tx_data  = tx_mem[tx_rp];

  wire tx_acc = wr_data && !tx_full;
  wire tx_pop = tx_valid && tx_ready;
  wire rx_acc = rx_valid && !rx_full;
  wire rx_pop = rd_data && rx_any;

  wire en_chg = wr_fcr && (reg_wdata[0] != fifo_en);
  wire tx_clr = wr_fcr && (reg_wdata[2] || en_chg);
  wire rx_clr = wr_fcr && (reg_wdata[1] || en_chg);
  wire drained = tx_pop && tx_cnt == CW'(1) && !tx_acc && !tx_clr;

  assign unused_bits = ^reg_wdata[5:3];

  always_comb begin
    level = LV0;
    if (fifo_en)
      case (trig)
        2'd0: level = LV0;
        2'd1: level = LV1;
        2'd2: level = LV2;
        default: level = LV3;
      endcase
  end

  wire src_rx   = ier[0] && rx_cnt >= level;
  wire src_thre = ier[1] && thre_pend;
  assign iir = src_rx ? 8'h04 : (src_thre ? 8'h02 : 8'h01);
  assign irq = src_rx || src_thre;
  assign lsr = {1'b0, tx_ovf, thre, 3'b000, rx_ovr, rx_any};

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = rx_any ? rx_mem[rx_rp] : 8'h00;
      3'd1:    reg_rdata = {6'b0, ier};
      3'd2:    reg_rdata = iir;
      3'd3:    reg_rdata = lsr;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tx_acc) tx_mem[tx_wp] <= reg_wdata;
    if (rx_acc) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_acc) tx_wp <= tx_wp + PW'(1);
      if (tx_pop) tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + CW'(tx_acc) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_acc) rx_wp <= rx_wp + PW'(1);
      if (rx_pop) rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + CW'(rx_acc) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_en <= 1'b0; trig <= 2'b00; ier <= 2'b00;
      thre_pend <= 1'b0; tx_ovf <= 1'b0; rx_ovr <= 1'b0;
    end else begin
      if (wr_fcr) begin
        fifo_en <= reg_wdata[0];
        trig    <= reg_wdata[7:6];
      end
      if (wr_ier) ier <= reg_wdata[1:0];
      if (drained) thre_pend <= 1'b1;
      else if (wr_data || (rd_iir && iir == 8'h02)) thre_pend <= 1'b0;
      if (wr_data && tx_full) tx_ovf <= 1'b1;
      else if (rd_lsr) tx_ovf <= 1'b0;
      if (rx_valid && rx_full) rx_ovr <= 1'b1;
      else if (rd_lsr) rx_ovr <= 1'b0;
    end
  end

  // R2: occupancy never exceeds the active capacity
  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= cap && rx_cnt <= cap);
  // R2: write to a full transmit FIFO raises the sticky flag
  p_tx_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && tx_cnt >= cap && !rd_lsr |=> lsr[6]);
  // R3: arrival at a full receive FIFO raises the sticky flag
  p_rx_ovr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_cnt >= cap && !rd_lsr |=> lsr[1]);
  // R5: an accepted write leaves the transmit side non-empty
  p_thre_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && !tx_full && !tx_clr |=> !lsr[5]);
  // R6: the final byte leaving marks the drained event
  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_cnt == CW'(1) && !wr_data && !wr_fcr |=> thre_pend);
  // R7: a data write removes a pending drained event unless the last byte leaves alone
  p_wr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && !(tx_ready && tx_cnt == CW'(1) && tx_full) |=> !thre_pend);
  // R10: transmit reset empties that FIFO in one clock
  p_tx_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fcr && reg_wdata[2] |=> !tx_valid);
endmodule

// File: tb/tb_uart_fifo_irq.sv
module tb_uart_fifo_irq;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, tx_ready = 0, rx_valid = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, rx_data = 0;
  logic [7:0] reg_rdata, tx_data;
  logic tx_valid, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  uart_fifo_irq dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic pop_tx(input logic [7:0] exp);
    @(negedge clk);
    check("R4 valid", tx_valid, 1);
    check("R4 data", tx_data, exp);
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  function automatic int lvl(int t);
    return t == 0 ? 1 : t == 1 ? 4 : t == 2 ? 8 : 14;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk(3, 8'h20, "R1 status");
    rd_chk(2, 8'h01, "R1 identity");
    rd_chk(1, 8'h00, "R1 enable");
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);
    // R6 enabling alone raises nothing
    wr(1, 8'h02);
    check("R6 enable alone", irq, 0);
    wr(1, 8'h00);

    // R2 single-byte mode
    wr(0, 8'hA5);
    wr(0, 8'h5A);
    rd_chk(3, 8'h40, "R2 overflow single");
    rd_chk(3, 8'h00, "R2 overflow cleared");
    pop_tx(8'hA5);
    check("R2 second dropped", tx_valid, 0);
    rd_chk(3, 8'h20, "R5 empty again");

    // 16-deep mode, fill, overflow and drain in order
    wr(2, 8'h01);
    wr(0, 8'h10);
    rd_chk(3, 8'h00, "R5 cleared by first write");
    wr(1, 8'h02);
    check("R6 no irq while queued", irq, 0);
    for (int i = 1; i < 16; i++) wr(0, 8'(8'h10 + i * 7));
    rd_chk(3, 8'h00, "R2 sixteen accepted");
    wr(0, 8'hEE);
    rd_chk(3, 8'h40, "R2 overflow at 16");
    for (int i = 0; i < 16; i++) begin
      pop_tx(8'(8'h10 + i * 7));
      if (i < 15) begin
        check("R6 no partial-empty irq", irq, 0);
        check("R5 still busy", tx_valid, 1);
      end
    end
    check("R6 irq after drain", irq, 1);
    check("R2 extra byte dropped", tx_valid, 0);
    rd_chk(2, 8'h02, "R6 identity");
    check("R7 cleared by identity read", irq, 0);
    rd_chk(2, 8'h01, "R7 nothing pending");

    // R7 clear by data write
    wr(0, 8'h33);
    pop_tx(8'h33);
    check("R6 drained again", irq, 1);
    wr(0, 8'h44);
    check("R7 cleared by write", irq, 0);

    // write and final pop in the same cycle
    @(negedge clk); reg_addr = 0; reg_wdata = 8'h55; reg_wr = 1; tx_ready = 1;
    @(negedge clk); reg_wr = 0; tx_ready = 0;
    check("R6 collision no irq", irq, 0);
    check("R4 collision valid", tx_valid, 1);
    check("R4 collision data", tx_data, 8'h55);
    rd_chk(3, 8'h00, "R5 collision busy");
    pop_tx(8'h55);
    check("R6 after collision drain", irq, 1);
    rd_chk(2, 8'h02, "R7 identity read");

    // R8 threshold sweep with R3 overrun and R11 ordering
    wr(1, 8'h01);
    for (int t = 0; t < 4; t++) begin
      wr(2, 8'(t * 64 + 3));
      check("R10 rx reset", irq, 0);
      for (int k = 1; k <= 16; k++) begin
        push_rx(8'(k * 11 + t));
        check($sformatf("R8 fill t=%0d k=%0d", t, k), irq, k >= lvl(t) ? 1 : 0);
      end
      push_rx(8'hFF);
      rd_chk(3, 8'h23, "R3 overrun");
      rd_chk(3, 8'h21, "R3 overrun cleared");
      for (int k = 1; k <= 16; k++) begin
        rd_chk(0, 8'(k * 11 + t), "R11 order");
        check($sformatf("R8 drain t=%0d k=%0d", t, k), irq, (16 - k) >= lvl(t) ? 1 : 0);
      end
      rd_chk(3, 8'h20, "R11 empty");
    end

    // R9 priority
    wr(2, 8'h43);
    wr(1, 8'h03);
    wr(0, 8'h66);
    pop_tx(8'h66);
    check("R6 pending", irq, 1);
    for (int k = 0; k < 4; k++) push_rx(8'(k));
    rd_chk(2, 8'h04, "R9 rx first");
    rd_chk(0, 8'h00, "R11 first byte");
    rd_chk(2, 8'h02, "R9 drained still pending");
    check("R7 cleared after report", irq, 0);
    for (int k = 1; k < 4; k++) rd_chk(0, 8'(k), "R11 rest");

    // R3 arrival at full FIFO together with a read
    for (int k = 0; k < 16; k++) push_rx(8'(8'h80 + k));
    @(negedge clk); rx_data = 8'hFF; rx_valid = 1; reg_addr = 0; reg_rd = 1;
    #1 v = reg_rdata;
    @(negedge clk); rx_valid = 0; reg_rd = 0;
    check("R11 collision read", v, 8'h80);
    rd_chk(3, 8'h23, "R3 collision overrun");
    for (int k = 1; k < 16; k++) rd_chk(0, 8'(8'h80 + k), "R3 dropped byte absent");
    rd_chk(3, 8'h20, "R3 empty after drain");

    // R10 selective resets
    for (int k = 0; k < 5; k++) push_rx(8'(k));
    wr(0, 8'h77);
    wr(0, 8'h78);
    wr(2, 8'h45);
    check("R10 tx emptied", tx_valid, 0);
    rd_chk(3, 8'h21, "R10 rx kept");
    check("R10 threshold kept", irq, 1);
    rd_chk(2, 8'h04, "R10 identity rx");
    wr(2, 8'h03);
    rd_chk(3, 8'h20, "R10 rx emptied");
    check("R10 no irq", irq, 0);
    push_rx(8'h12);
    check("R8 level 1", irq, 1);
    wr(2, 8'h00);
    rd_chk(3, 8'h20, "R10 disable empties");
    push_rx(8'h21);
    check("R8 disabled level", irq, 1);
    push_rx(8'h22);
    rd_chk(3, 8'h23, "R3 single-byte overrun");
    rd_chk(0, 8'h21, "R11 single byte");

    finish_run();
  end
endmodule